// File: doc/BRIEF.md
# Power-management mailbox command interface

This block is a device-side mailbox through which a host processor hands commands to a power-management controller. The host sees four 32-bit registers on a simple memory-mapped write/read bus: a low data word, a high data word, a command/status word and an interrupt-pending word. The host first loads its input data, then writes a command word with the run flag set. The block then presents the opcode, both byte parameters and both data words to the controller on a valid/ready request port.

The controller answers with a single-cycle response that carries an error code and two result words. The block stores the result words in the data registers and writes the error code into the low byte of the status word. It then clears the run flag and pulses a completion interrupt. A sticky pending bit keeps a record of that pulse. A host can either take the interrupt or poll the run flag until it reads 0.

A parameter selects the channel kind. A wide channel exchanges 64 bits of data. A narrow channel exchanges only the low word, and its high word is absent.

Top module: `pm_mbox`

## Requirements
- R1: After reset every register reads 0, no request is offered, and the interrupt is low.
- R2: The host write bus selects a register by word index: 0 is the low data word, 1 the high data word, 2 the command/status word and 3 the pending word. Command word layout: bit 31 is run, bits 23:16 are the second parameter, bits 15:8 are the first parameter and bits 7:0 are the opcode. An idle write to index 2 with bit 31 set offers a request from the next cycle, carrying exactly those fields and the two data words. The status word then reads bit 31 as 1, bits 30:24 as 0 and the other fields as written.
- R3: While a request is offered and not yet accepted, it stays offered and its payload does not change.
- R4: A write to the command word while the run flag is set is ignored. An idle write with bit 31 clear stores the fields and starts nothing.
- R5: While the run flag is set, host writes to either data word are ignored.
- R6: On the response edge after acceptance, the block latches the result words into the data registers and puts the error code in status bits 7:0. It clears the run flag and leaves both parameter fields unchanged.
- R7: A response strobe that arrives before the request has been accepted, or while idle, is ignored.
- R8: The interrupt is high for exactly the one cycle after the response edge.
- R9: Pending bit 0 (index 3) sets with each completion and stays set until the host writes index 3 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. A completion in the same cycle as a clearing write leaves it set.
- R10: In the narrow variant the high data word reads 0, host writes to it are ignored, the request carries 0 there, and the response high word is discarded.
- R11: Error codes are 0 success, 1 invalid command, 2 invalid parameter, 3 timeout, 4 locked, 5 invalid regulator ID and 6 regulator fault. Any code, including values above 6, is reported unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_word_addr | input | 2 | Host register word index |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from the index |
| req_valid | output | 1 | Request offered to the controller |
| req_ready | input | 1 | Controller accepts the request |
| req_opcode | output | 8 | Command opcode |
| req_p1 | output | 8 | First parameter |
| req_p2 | output | 8 | Second parameter |
| req_data_lo | output | 32 | Input data, low word |
| req_data_hi | output | 32 | Input data, high word (0 when narrow) |
| rsp_valid | input | 1 | Controller response strobe |
| rsp_err | input | 8 | Completion error code |
| rsp_data_lo | input | 32 | Result data, low word |
| rsp_data_hi | input | 32 | Result data, high word |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench drives a wide and a narrow instance in lockstep through a sweep of opcodes, parameters and every error code from 0 to 7. A design that let busy-time writes through would show corrupted request fields or data that no longer matches what the host loaded. An early response strobe, sent while the request is still waiting, would finish the command with a bogus error if it were not ignored. A clearing write that lands on a completion edge would lose the pending bit if the clear took priority. The narrow instance would leak the controller's high word if the variant were wired wrong.

// File: rtl/pm_mbox_pkg.sv
package pm_mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DLO  = 2'd0,
    REG_DHI  = 2'd1,
    REG_CMD  = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  typedef enum logic [BYTE_W-1:0] {
    ERR_NONE       = 8'd0,
    ERR_BAD_OPCODE = 8'd1,
    ERR_BAD_ARG    = 8'd2,
    ERR_TIMEOUT    = 8'd3,
    ERR_LOCKED     = 8'd4,
    ERR_BAD_RAIL   = 8'd5,
    ERR_RAIL_FAULT = 8'd6
  } mbox_err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic              run;
    logic [6:0]        rsv;
    logic [BYTE_W-1:0] p2;
    logic [BYTE_W-1:0] p1;
    logic [BYTE_W-1:0] low;
  } cmd_word_t;

  // Host word to stored command: reserved bits are dropped.
  function automatic cmd_word_t take_cmd(logic [WORD_W-1:0] w);
    cmd_word_t c;
    c     = cmd_word_t'(w);
    c.rsv = '0;
    return c;
  endfunction

  // Stored command after completion: error code replaces the low byte.
  function automatic cmd_word_t finish_cmd(cmd_word_t c, logic [BYTE_W-1:0] err);
    cmd_word_t r;
    r     = c;
    r.run = 1'b0;
    r.low = err;
    return r;
  endfunction
endpackage

// File: rtl/pm_mbox_seq.sv
module pm_mbox_seq
  import pm_mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic busy,
  output logic done
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ISSUE;
      ST_ISSUE: if (req_ready) st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_valid = (st_q == ST_ISSUE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_WAIT) && rsp_valid;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  assert_early_rsp_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid |=> busy);

  assert_done_goes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !req_valid);
endmodule

// File: rtl/pm_mbox_irq.sv
module pm_mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic pend_clr,
  output logic irq,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      pend <= 1'b0;
    end else begin
      irq <= done;
      if (done)          pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
    end
  end

  assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_sets_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !pend_clr |=> pend);
endmodule

// File: rtl/pm_mbox_regs.sv
module pm_mbox_regs
  import pm_mbox_pkg::*;
#(
  parameter bit WIDE_CHAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_word_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              pend,
  input  logic [BYTE_W-1:0] rsp_err,
  input  logic [WORD_W-1:0] rsp_lo,
  input  logic [WORD_W-1:0] rsp_hi,
  output logic              start,
  output logic              pend_clr,
  output cmd_word_t         cmd,
  output logic [WORD_W-1:0] data_lo,
  output logic [WORD_W-1:0] data_hi
);
  reg_sel_e sel;
  logic     wr_cmd_ok, wr_lo_ok, wr_hi_ok;

  assign sel       = reg_sel_e'(bus_word_addr);
  assign wr_cmd_ok = bus_wr && (sel == REG_CMD) && !busy;
  assign wr_lo_ok  = bus_wr && (sel == REG_DLO) && !busy;
  assign wr_hi_ok  = bus_wr && (sel == REG_DHI) && !busy;
  assign start     = wr_cmd_ok && bus_wdata[WORD_W-1];
  assign pend_clr  = bus_wr && (sel == REG_PEND) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd     <= '0;
      data_lo <= '0;
    end else begin
      if (done)           cmd <= finish_cmd(cmd, rsp_err);
      else if (wr_cmd_ok) cmd <= take_cmd(bus_wdata);
      if (done)           data_lo <= rsp_lo;
      else if (wr_lo_ok)  data_lo <= bus_wdata;
    end
  end

  generate
    if (WIDE_CHAN) begin : g_wide
      logic [WORD_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        hi_q <= '0;
        else if (done)     hi_q <= rsp_hi;
        else if (wr_hi_ok) hi_q <= bus_wdata;
      end
      assign data_hi = hi_q;
    end else begin : g_narrow
      assign data_hi = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      REG_DLO:  bus_rdata = data_lo;
      REG_DHI:  bus_rdata = data_hi;
      REG_CMD:  bus_rdata = WORD_W'(cmd);
      REG_PEND: bus_rdata = {{(WORD_W-1){1'b0}}, pend};
      default:  bus_rdata = '0;
    endcase
  end

  assert_run_tracks_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.run == busy);

  assert_busy_cmd_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && (sel == REG_CMD) && !done |=> cmd == $past(cmd));

  assert_busy_data_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> data_lo == $past(data_lo) && data_hi == $past(data_hi));

  assert_completion_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> data_lo == $past(rsp_lo) && cmd.low == $past(rsp_err) && !cmd.run);
endmodule

// File: rtl/pm_mbox.sv
module pm_mbox
  import pm_mbox_pkg::*;
#(
  parameter bit WIDE_CHAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_word_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BYTE_W-1:0] req_opcode,
  output logic [BYTE_W-1:0] req_p1,
  output logic [BYTE_W-1:0] req_p2,
  output logic [WORD_W-1:0] req_data_lo,
  output logic [WORD_W-1:0] req_data_hi,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_err,
  input  logic [WORD_W-1:0] rsp_data_lo,
  input  logic [WORD_W-1:0] rsp_data_hi,
  output logic              done_irq
);
  logic      start, busy, done, pend, pend_clr;
  cmd_word_t cmd;

  pm_mbox_regs #(.WIDE_CHAN(WIDE_CHAN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .pend(pend), .rsp_err(rsp_err), .rsp_lo(rsp_data_lo), .rsp_hi(rsp_data_hi),
    .start(start), .pend_clr(pend_clr), .cmd(cmd), .data_lo(req_data_lo),
    .data_hi(req_data_hi)
  );

  pm_mbox_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .req_valid(req_valid), .busy(busy), .done(done)
  );

  pm_mbox_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .pend_clr(pend_clr),
    .irq(done_irq), .pend(pend)
  );

  assign req_opcode = cmd.low;
  assign req_p1     = cmd.p1;
  assign req_p2     = cmd.p2;

  assert_start_offers_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req_valid && req_opcode == $past(bus_wdata[7:0])
              && req_p1 == $past(bus_wdata[15:8]) && req_p2 == $past(bus_wdata[23:16]));

  assert_payload_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_opcode) && $stable(req_p1)
                                && $stable(req_p2) && $stable(req_data_lo)
                                && $stable(req_data_hi));

  assert_narrow_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !WIDE_CHAN |-> req_data_hi == '0);
endmodule

// File: tb/test_pm_mbox.sv
module test_pm_mbox;
  import pm_mbox_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_err = '0;
  logic [31:0] rsp_data_lo = '0, rsp_data_hi = '0;

  logic [31:0] rd_w, rd_n, dlo_w, dlo_n, dhi_w, dhi_n;
  logic        rv_w, rv_n, irq_w, irq_n;
  logic [7:0]  op_w, op_n, p1_w, p1_n, p2_w, p2_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_mbox #(.WIDE_CHAN(1'b1)) i_pm_mbox (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_w), .req_valid(rv_w), .req_ready(req_ready),
    .req_opcode(op_w), .req_p1(p1_w), .req_p2(p2_w), .req_data_lo(dlo_w),
    .req_data_hi(dhi_w), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data_lo(rsp_data_lo), .rsp_data_hi(rsp_data_hi), .done_irq(irq_w)
  );

  pm_mbox #(.WIDE_CHAN(1'b0)) i_pm_mbox_narrow (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_n), .req_valid(rv_n), .req_ready(req_ready),
    .req_opcode(op_n), .req_p1(p1_n), .req_p2(p2_n), .req_data_lo(dlo_n),
    .req_data_hi(dhi_n), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data_lo(rsp_data_lo), .rsp_data_hi(rsp_data_hi), .done_irq(irq_n)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_word_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] w, output logic [31:0] n);
    bus_word_addr = a;
    #1;
    w = rd_w; n = rd_n;
  endtask

  function automatic logic [31:0] status_of(logic run, logic [7:0] p2, logic [7:0] p1,
                                            logic [7:0] low);
    return (32'(run) << 31) | (32'(p2) << 16) | (32'(p1) << 8) | 32'(low);
  endfunction

  task automatic run_cmd(logic [7:0] op, logic [7:0] p1, logic [7:0] p2,
                         logic [31:0] lo, logic [31:0] hi, logic [7:0] err,
                         logic [31:0] rlo, logic [31:0] rhi, bit clr_same);
    logic [31:0] w, n;
    wr(2'd0, lo);
    wr(2'd1, hi);
    wr(2'd2, status_of(1'b1, p2, p1, op) | 32'h7F00_0000);
    // R2: request offered with written fields
    chk("R2 req_valid", {rv_w, rv_n}, 2'b11);
    chk("R2 opcode", {op_w, op_n}, {op, op});
    chk("R2 p1", {p1_w, p1_n}, {p1, p1});
    chk("R2 p2", {p2_w, p2_n}, {p2, p2});
    chk("R2 data_lo", dlo_w ^ dlo_n, 32'h0);
    chk("R2 data_lo w", dlo_w, lo);
    chk("R2 data_hi w", dhi_w, hi);
    chk("R10 data_hi narrow", dhi_n, 32'h0);
    rd(2'd2, w, n);
    chk("R2 status w", w, status_of(1'b1, p2, p1, op));
    chk("R2 status n", n, status_of(1'b1, p2, p1, op));
    // R7: early response must be ignored
    rsp_valid = 1'b1; rsp_err = 8'hEE; rsp_data_lo = ~lo; rsp_data_hi = ~hi;
    tick();
    rsp_valid = 1'b0;
    chk("R7 still offered", {rv_w, rv_n, irq_w, irq_n}, 4'b1100);
    rd(2'd2, w, n);
    chk("R7 status unchanged", w, status_of(1'b1, p2, p1, op));
    // R4: busy command write ignored
    wr(2'd2, status_of(1'b1, ~p2, ~p1, ~op));
    rd(2'd2, w, n);
    chk("R4 busy cmd write w", w, status_of(1'b1, p2, p1, op));
    chk("R4 busy cmd write n", n, status_of(1'b1, p2, p1, op));
    chk("R3 payload held", {op_w, p1_w, p2_w}, {op, p1, p2});
    // R5: busy data writes ignored
    wr(2'd0, ~lo);
    wr(2'd1, ~hi);
    rd(2'd0, w, n);
    chk("R5 lo protected", {w ^ lo, n ^ lo}, 64'h0);
    rd(2'd1, w, n);
    chk("R5 hi protected w", w, hi);
    chk("R10 hi write ignored n", n, 32'h0);
    chk("R3 data held", dlo_w, lo);
    // accept
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk("R3 accepted", {rv_w, rv_n}, 2'b00);
    rd(2'd2, w, n);
    chk("R6 run while waiting", {w[31], n[31]}, 2'b11);
    wr(2'd0, lo ^ 32'h0F0F_0000);
    rd(2'd0, w, n);
    chk("R5 lo protected in wait", w, lo);
    // completion
    rsp_valid = 1'b1; rsp_err = err; rsp_data_lo = rlo; rsp_data_hi = rhi;
    if (clr_same) begin
      bus_wr = 1'b1; bus_word_addr = 2'd3; bus_wdata = 32'h1;
    end
    tick();
    rsp_valid = 1'b0; bus_wr = 1'b0;
    chk("R8 irq pulse", {irq_w, irq_n}, 2'b11);
    rd(2'd2, w, n);
    chk("R6 R11 status w", w, status_of(1'b0, p2, p1, err));
    chk("R6 R11 status n", n, status_of(1'b0, p2, p1, err));
    rd(2'd0, w, n);
    chk("R6 result lo", {w, n}, {rlo, rlo});
    rd(2'd1, w, n);
    chk("R6 result hi w", w, rhi);
    chk("R10 result hi n", n, 32'h0);
    rd(2'd3, w, n);
    chk(clr_same ? "R9 set wins over clear" : "R9 pending set", {w, n}, {32'h1, 32'h1});
    tick();
    chk("R8 irq single cycle", {irq_w, irq_n}, 2'b00);
    wr(2'd3, 32'h0);
    rd(2'd3, w, n);
    chk("R9 zero write keeps", {w, n}, {32'h1, 32'h1});
    wr(2'd3, 32'h1);
    rd(2'd3, w, n);
    chk("R9 cleared", {w, n}, 64'h0);
  endtask

  initial begin
    logic [31:0] w, n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), w, n);
      chk("R1 reg reset", {w, n}, 64'h0);
    end
    chk("R1 idle outputs", {rv_w, rv_n, irq_w, irq_n}, 4'b0000);
    // R4: idle write without run bit stores but starts nothing
    wr(2'd2, status_of(1'b0, 8'h12, 8'h34, 8'h56));
    tick();
    chk("R4 no start", {rv_w, rv_n}, 2'b00);
    rd(2'd2, w, n);
    chk("R4 stored fields", {w, n}, {2{status_of(1'b0, 8'h12, 8'h34, 8'h56)}});
    // sweep over error codes and payload patterns
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = 8'(i % 8);
      if (e != 8'd7) chk("R11 code known", 32'(e <= ERR_RAIL_FAULT), 32'h1);
      run_cmd(8'(i * 17), 8'(8'hFF - i * 3), 8'((i << 4) | i),
              32'hA5A5_5A5A ^ (32'(i) << 24), 32'h3C3C_C3C3 + 32'(i),
              e, 32'h1111_0000 + 32'(i * 7), 32'hFEED_0000 | 32'(i), (i % 4) == 3);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule